// File: doc/BRIEF.md
# Codec offset calibration sequencer

This block decides when the input offset calibration of an audio converter runs and controls the serial output while it runs. Two events request a calibration. One is the release of the active-low reset. The other is a rising edge on the data/control select, which marks a move from control mode to data mode. A request that arrives while the voltage reference is still settling is held as pending. It runs once a settling interval of `SETTLE_MS` millisecond ticks has passed since reset release or since power-down was removed.

A calibration lasts `CAL_FRAMES` frame-sync strobes. Throughout that time the block forces the serial output data to zero and holds the A/D-invalid status bit high. It latches the input-select bit at the start and presents that value to the calibration engine for the whole cycle. The other control inputs have no effect while a calibration runs. A change of the input-select bit during a calibration sets a sticky warning. A power-down request aborts a calibration in progress, sets the A/D-invalid bit and restarts the settling interval. The calibration then runs again once the interval has passed.

Top module: `ofs_cal_seq`

## Requirements
- R1: After reset is released, a calibration starts without any other trigger, once the settling interval has passed.
- R2: A rising edge on `dc_sel` (0 = control mode, 1 = data mode) while the block is idle and settled starts a calibration within two clock cycles.
- R3: No calibration starts until `SETTLE_MS` ticks of `ms_tick` have been counted since reset release or since `pwr_dn` fell. A trigger that arrives earlier is held and starts the calibration as soon as the count is reached.
- R4: A completed calibration spans exactly `CAL_FRAMES` `fsync` strobes, counted in the cycles where `calibrating` is 1.
- R5: `sdout_zero` is 1 in every cycle in which `calibrating` is 1, and 0 when the block is idle.
- R6: `adc_invalid` is 1 while reset is held and throughout a calibration. It is 0 from the cycle after the last frame of a completed calibration.
- R7: `cal_in_sel` takes the value of `in_sel` at the start of a calibration and stays constant until that calibration ends.
- R8: Edges on `dc_sel` during a calibration neither lengthen it nor cause another calibration after it.
- R9: `sel_warn` becomes 1 if `in_sel` differs from `cal_in_sel` during a calibration, and it stays 1 until reset.
- R10: `pwr_dn` = 1 ends a calibration in progress on the next clock and sets `adc_invalid`. After `pwr_dn` returns to 0, a new calibration runs once the settling interval has passed again.
- R11: `cal_done` is a single-cycle pulse in the cycle after a calibration completes. It does not pulse when a calibration is aborted.
- R12: With no trigger, the block stays idle with `calibrating` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dc_sel | input | 1 | Mode select: 0 control mode, 1 data mode |
| pwr_dn | input | 1 | Power-down request, active high |
| in_sel | input | 1 | Input channel select to be calibrated |
| fsync | input | 1 | One-clock frame-sync strobe |
| ms_tick | input | 1 | One-clock strobe per millisecond |
| calibrating | output | 1 | High while a calibration runs |
| sdout_zero | output | 1 | Forces the serial output data bits to zero |
| adc_invalid | output | 1 | A/D-invalid status bit for the output frame |
| cal_in_sel | output | 1 | Input select held for the calibration engine |
| cal_done | output | 1 | One-clock pulse when a calibration completes |
| sel_warn | output | 1 | Sticky flag: input select changed during calibration |

## Verification
A wrong frame count shows up at the ports within one calibration. `calibrating` falls one or more strobes away from `CAL_FRAMES`, and the edges of `adc_invalid` and `cal_done` move with it. A lost pending trigger or a settling counter that does not restart shows one of two ways. Either `calibrating` never rises, or it rises before the bench has issued `SETTLE_MS` ticks after reset or power-down exit. This is caught at the first start after the fault. A corrupted capture register shows as a change of `cal_in_sel` or a wrong `sel_warn` within the same calibration.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CAL  = 1'b1
  } cal_state_e;
endpackage

// File: rtl/ocs_rst_sync.sv
module ocs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ocs_settle_guard.sv
module ocs_settle_guard #(
  parameter int SETTLE_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ms_tick,
  output logic ready
);
  localparam int GW = $clog2(SETTLE_MS + 1);
  localparam logic [GW-1:0] LIMIT = GW'(SETTLE_MS);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign ready  = (cnt_q == LIMIT);
  assign cnt_en = restart | (ms_tick & ~ready);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (ms_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocs_frame_timer.sv
module ocs_frame_timer #(
  parameter int CAL_FRAMES = 194
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic fsync,
  output logic last
);
  localparam int CW = (CAL_FRAMES > 1) ? $clog2(CAL_FRAMES) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(CAL_FRAMES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == LAST_IDX);
  assign last    = run & fsync & at_last;
  assign cnt_en  = load | (run & fsync);

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
  import ocs_pkg::*;
#(
  parameter int SETTLE_MS  = 50,
  parameter int CAL_FRAMES = 194
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dc_sel,
  input  logic pwr_dn,
  input  logic in_sel,
  input  logic fsync,
  input  logic ms_tick,
  output logic calibrating,
  output logic sdout_zero,
  output logic adc_invalid,
  output logic cal_in_sel,
  output logic cal_done,
  output logic sel_warn
);
  logic       srst_n;
  cal_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       inv_q, inv_d;
  logic       sel_q, sel_d;
  logic       warn_q, warn_d;
  logic       done_q, done_d;
  logic       dc_q;
  logic       guard_ok, frame_last;
  logic       dc_rise, in_cal, start, abort, finish;

  ocs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(srst_n)
  );

  ocs_settle_guard #(.SETTLE_MS(SETTLE_MS)) u_guard (
    .clk(clk), .rst_n(srst_n), .restart(pwr_dn), .ms_tick(ms_tick),
    .ready(guard_ok)
  );

  ocs_frame_timer #(.CAL_FRAMES(CAL_FRAMES)) u_timer (
    .clk(clk), .rst_n(srst_n), .load(start), .run(in_cal), .fsync(fsync),
    .last(frame_last)
  );

  assign in_cal  = (state_q == ST_CAL);
  assign dc_rise = dc_sel & ~dc_q;
  assign start   = ~in_cal & pend_q & guard_ok & ~pwr_dn;
  assign abort   = in_cal & pwr_dn;
  assign finish  = in_cal & ~pwr_dn & frame_last;

  always_comb begin
    state_d = state_q;
    if (start)                state_d = ST_CAL;
    else if (abort || finish) state_d = ST_IDLE;
  end

  always_comb begin
    pend_d = pend_q;
    if (pwr_dn)                pend_d = 1'b1;
    else if (start)            pend_d = 1'b0;
    else if (!in_cal && dc_rise) pend_d = 1'b1;
  end

  always_comb begin
    inv_d = inv_q;
    if (pwr_dn || start) inv_d = 1'b1;
    else if (finish)     inv_d = 1'b0;
  end

  always_comb begin
    sel_d  = start ? in_sel : sel_q;
    warn_d = warn_q | (in_cal & (in_sel != sel_q));
    done_d = finish;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b1;
      inv_q   <= 1'b1;
      sel_q   <= 1'b0;
      warn_q  <= 1'b0;
      done_q  <= 1'b0;
      dc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      inv_q   <= inv_d;
      if (start) sel_q <= sel_d;
      warn_q  <= warn_d;
      done_q  <= done_d;
      dc_q    <= dc_sel;
    end
  end

  assign calibrating = in_cal;
  assign sdout_zero  = in_cal;
  assign adc_invalid = inv_q;
  assign cal_in_sel  = sel_q;
  assign cal_done    = done_q;
  assign sel_warn    = warn_q;
endmodule

// File: rtl/ofs_cal_seq_chk.sv
module ofs_cal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_dn,
  input logic calibrating,
  input logic sdout_zero,
  input logic adc_invalid,
  input logic cal_in_sel,
  input logic cal_done,
  input logic sel_warn
);
  a_r5_zero_implies_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    sdout_zero |-> adc_invalid);

  a_r7_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (calibrating && $past(calibrating)) |-> $stable(cal_in_sel));

  a_r9_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sel_warn |=> sel_warn);

  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!calibrating && adc_invalid));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  a_r6_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!adc_invalid && !calibrating));
endmodule

bind ofs_cal_seq ofs_cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .calibrating(calibrating),
  .sdout_zero(sdout_zero), .adc_invalid(adc_invalid), .cal_in_sel(cal_in_sel),
  .cal_done(cal_done), .sel_warn(sel_warn)
);

// File: tb/test_ofs_cal_seq.sv
module test_ofs_cal_seq;
  localparam int SETTLE = 50;
  localparam int FRAMES = 194;
  localparam int FS_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, dc_sel = 1'b0, pwr_dn = 1'b0, in_sel = 1'b0;
  logic fsync = 1'b0, ms_tick = 1'b0;
  logic calibrating, sdout_zero, adc_invalid, cal_in_sel, cal_done, sel_warn;

  int checks = 0, failures = 0;
  int ticks_driven = 0;
  int tick_per = 4;
  bit finished = 0;

  always #2 clk = ~clk;

  ofs_cal_seq #(.SETTLE_MS(SETTLE), .CAL_FRAMES(FRAMES)) i_ofs_cal_seq (
    .clk(clk), .rst_n(rst_n), .dc_sel(dc_sel), .pwr_dn(pwr_dn), .in_sel(in_sel),
    .fsync(fsync), .ms_tick(ms_tick), .calibrating(calibrating),
    .sdout_zero(sdout_zero), .adc_invalid(adc_invalid), .cal_in_sel(cal_in_sel),
    .cal_done(cal_done), .sel_warn(sel_warn)
  );

  // strobe generators, driven on the falling edge
  initial begin
    int fs_ph = 0;
    int tk_ph = 0;
    forever begin
      @(negedge clk);
      fsync = (fs_ph == FS_DIV - 1);
      fs_ph = (fs_ph == FS_DIV - 1) ? 0 : fs_ph + 1;
      ms_tick = (tk_ph >= tick_per - 1);
      if (ms_tick) begin
        tk_ph = 0;
        ticks_driven++;
      end else tk_ph++;
    end
  end

  function automatic bit in_window(int v, int lo, int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_start(int limit, output int waited);
    waited = 0;
    while (!calibrating && waited < limit) begin
      step();
      waited++;
    end
  endtask

  task automatic run_cal(bit chg_sel, bit wig_dc, int abort_at,
                         output int frames, output bit bad_zero, output bit bad_sel);
    logic cap;
    int guard_cnt = 0;
    cap = cal_in_sel;
    frames = 0; bad_zero = 0; bad_sel = 0;
    while (calibrating && guard_cnt < 4000) begin
      if (!sdout_zero || !adc_invalid) bad_zero = 1;
      if (cal_in_sel != cap) bad_sel = 1;
      if (fsync) frames++;
      if (chg_sel && frames == 20) in_sel = ~cap;
      if (wig_dc && frames == 30) dc_sel = 1'b0;
      if (wig_dc && frames == 60) dc_sel = 1'b1;
      if (abort_at > 0 && frames == abort_at) pwr_dn = 1'b1;
      step();
      guard_cnt++;
    end
  endtask

  task automatic idle_check(int n, string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (calibrating) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic full_cal_checks(string tag);
    int fr; bit bz, bs;
    run_cal(1'b0, 1'b0, 0, fr, bz, bs);
    chk(fr == FRAMES, "R4", fr, FRAMES);
    chk(!bz, "R5", bz, 0);
    chk(cal_done == 1'b1 && adc_invalid == 1'b0, "R6", {cal_done, adc_invalid}, 2);
    step();
    chk(cal_done == 1'b0, "R11", cal_done, 0);
    if (tag.len() == 0) ;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, fr, ab;
    bit bz, bs;
    logic sel0;
    void'($urandom(32'd4215));

    // reset values
    repeat (10) step();
    chk(calibrating == 0 && sdout_zero == 0, "R5", calibrating, 0);
    chk(adc_invalid == 1'b1, "R6", adc_invalid, 1);
    chk(cal_done == 0 && sel_warn == 0, "R11", {cal_done, sel_warn}, 0);

    // R1 / R3: reset exit calibration, held by the settling guard
    tick_per = 3 + int'($urandom % 4);
    sel0 = 1'($urandom % 2);
    in_sel = sel0;
    rst_n = 1'b1;
    ticks_driven = 0;
    wait_start(2000, w);
    chk(calibrating == 1'b1, "R1", calibrating, 1);
    chk(ticks_driven >= SETTLE, "R3", ticks_driven, SETTLE);
    chk(in_window(ticks_driven, SETTLE, SETTLE + 2), "R1", ticks_driven, SETTLE);
    chk(cal_in_sel == sel0, "R7", cal_in_sel, sel0);
    run_cal(1'b0, 1'b1, 0, fr, bz, bs);
    chk(fr == FRAMES, "R8", fr, FRAMES);
    chk(!bz, "R5", bz, 0);
    chk(!bs, "R7", bs, 0);
    chk(cal_done == 1'b1 && adc_invalid == 1'b0, "R6", {cal_done, adc_invalid}, 2);
    chk(sel_warn == 1'b0, "R9", sel_warn, 0);
    step();
    chk(cal_done == 1'b0, "R11", cal_done, 0);
    chk(sdout_zero == 1'b0, "R5", sdout_zero, 0);
    idle_check(150, "R8");

    // R12: no trigger, stay idle
    dc_sel = 1'b0;
    idle_check(200, "R12");

    // R2: control to data edge, guard already satisfied
    sel0 = 1'($urandom % 2);
    in_sel = sel0;
    dc_sel = 1'b1;
    wait_start(8, w);
    chk(calibrating && w <= 2, "R2", w, 2);
    chk(cal_in_sel == sel0, "R7", cal_in_sel, sel0);
    run_cal(1'b1, 1'b0, 0, fr, bz, bs);
    chk(!bs, "R7", bs, 0);
    chk(fr == FRAMES, "R4", fr, FRAMES);
    chk(sel_warn == 1'b1, "R9", sel_warn, 1);
    step();

    // R10: abort in the middle, then recalibrate after the guard
    dc_sel = 1'b0;
    step();
    dc_sel = 1'b1;
    wait_start(8, w);
    chk(calibrating == 1'b1, "R2", calibrating, 1);
    ab = 10 + int'($urandom % 140);
    run_cal(1'b0, 1'b0, ab, fr, bz, bs);
    chk(fr < FRAMES && calibrating == 1'b0, "R10", fr, ab);
    chk(adc_invalid == 1'b1, "R10", adc_invalid, 1);
    chk(cal_done == 1'b0, "R11", cal_done, 0);
    for (int i = 0; i < 20; i++) step();
    chk(calibrating == 1'b0 && sel_warn == 1'b1, "R9", sel_warn, 1);
    tick_per = 3 + int'($urandom % 4);
    pwr_dn = 1'b0;
    ticks_driven = 0;
    wait_start(2000, w);
    chk(calibrating == 1'b1, "R10", calibrating, 1);
    chk(in_window(ticks_driven, SETTLE, SETTLE + 1), "R3", ticks_driven, SETTLE);
    full_cal_checks("after abort");

    // R10: power-down while idle, deferred dc edge inside the guard
    pwr_dn = 1'b1;
    step();
    step();
    chk(adc_invalid == 1'b1, "R10", adc_invalid, 1);
    dc_sel = 1'b0;
    step();
    pwr_dn = 1'b0;
    ticks_driven = 0;
    step();
    dc_sel = 1'b1;
    wait_start(2000, w);
    chk(in_window(ticks_driven, SETTLE, SETTLE + 1), "R3", ticks_driven, SETTLE);
    full_cal_checks("idle powerdown");
    idle_check(100, "R12");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule